// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the device end of a three-line serial link used to read and write an 8-bit register bank. An external master owns the serial clock. It raises an active-high select line, sends sixteen clock pulses and lowers the select again. The first seven bits of a frame carry the register address and the eighth carries the direction flag. On a write the master also sends the last eight bits, and the block hands one strobe with address and data to the bank. On a read the master lets go of the shared data wire after the flag. The block then fetches the byte from the bank and drives it back, most significant bit first.

All three serial inputs are oversampled by the fast system clock through a synchronizer, so every state element runs in one clock domain with a synchronous reset. The shared data wire is split into an input pin, an output value and an output enable. A pad cell outside the block combines them into the bidirectional wire.

Top module: `sio_reg_slave`

## Requirements
- R1: After reset, `sdo_oe`, `sdo`, `reg_wr` and `reg_rd` are all 0.
- R2: A frame holds bits 15..0 sent most significant first and sampled on serial-clock rising edges. Bits 15..9 are the address, bit 8 is the direction flag (0 = write) and bits 7..0 are the data. A complete write frame produces exactly one `reg_wr` pulse, carrying that address on `reg_addr` and that data on `reg_wdata`.
- R3: `reg_wr` is one system cycle wide. No `reg_rd` pulse appears during a write frame.
- R4: A write frame cut short by select falling before the 16th rising edge produces no `reg_wr`.
- R5: A frame with flag 1 produces exactly one one-cycle `reg_rd` pulse, with the latched address on `reg_addr`, and no `reg_wr`.
- R6: In a read frame, the bank byte on `reg_rdata` is taken after the 9th rising edge. `sdo` then shows bit 7 after the 9th edge, and one lower bit after each later edge through the 16th.
- R7: `sdo_oe` is 1 only from the 9th rising edge of a read frame until select falls. It stays 0 throughout write frames and while select is low.
- R8: Select low clears the bit position, so a frame that follows an aborted one is decoded from its first bit.
- R9: Rising edges after the 16th are ignored. No further write is issued and `sdo` keeps showing data bit 0.
- R10: Each serial input passes through `SYNC_STAGES` flip-flops. `sdo_oe` falls exactly `SYNC_STAGES`+1 system clock edges after select goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the master |
| csel | input | 1 | Active-high frame select from the master |
| sdi | input | 1 | Data wire as seen at the pad input |
| sdo | output | 1 | Value driven onto the data wire during read data |
| sdo_oe | output | 1 | Output enable for the data-wire pad driver |
| reg_addr | output | ADDR_W | Register address for the bank |
| reg_wdata | output | DATA_W | Write data for the bank |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read request |
| reg_rdata | input | DATA_W | Read byte from the bank, valid before the 9th edge |

## Verification
The bench builds the block with its defaults: a 7-bit address, an 8-bit datum and two synchronizer stages. With these values all 128 addresses can be written and read back in one run. Each address carries an arithmetically derived data byte, and a modelled bank returns a byte computed from the address. The same configuration also makes short aborted frames, overlong frames and the exact select-to-enable release delay quick to exercise.

// File: rtl/sio_pkg.sv
package sio_pkg;
  // width of the serial shift register: large enough for the address
  // and for all data bits but the last one sampled
  function automatic int shift_width(input int aw, input int dw);
    return (aw > dw - 1) ? aw : dw - 1;
  endfunction

  function automatic int count_width(input int frame_bits);
    return $clog2(frame_bits + 1);
  endfunction
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[0] <= '0;
        else     st[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[g] <= '0;
        else     st[g] <= st[g-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sio_frame.sv
module sio_frame
  import sio_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              rise,
  input  logic              sdi_s,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wr_o,
  output logic              rd_o,
  output logic              load_o,
  output logic              shift_o
);
  localparam int FRAME_W = ADDR_W + 1 + DATA_W;
  localparam int SH_W    = shift_width(ADDR_W, DATA_W);
  localparam int CNT_W   = count_width(FRAME_W);
  localparam logic [CNT_W-1:0] C_FLAG  = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] C_FIRST = CNT_W'(ADDR_W + 1);
  localparam logic [CNT_W-1:0] C_LAST  = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] C_END   = CNT_W'(FRAME_W);

  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  sh;
  logic             rd_flag;
  logic             take;

  assign take = rise && (cnt < C_END);

  // frame state, cleared while select is low
  always_ff @(posedge clk) begin
    if (rst || !cs_s) begin
      cnt     <= '0;
      sh      <= '0;
      rd_flag <= 1'b0;
      wr_o    <= 1'b0;
      rd_o    <= 1'b0;
      load_o  <= 1'b0;
      shift_o <= 1'b0;
    end else begin
      wr_o    <= 1'b0;
      rd_o    <= 1'b0;
      load_o  <= 1'b0;
      shift_o <= 1'b0;
      if (take) begin
        cnt <= cnt + 1'b1;
        sh  <= {sh[SH_W-2:0], sdi_s};
        if (cnt == C_FLAG) begin
          rd_flag <= sdi_s;
          rd_o    <= sdi_s;
        end
        if (cnt == C_FIRST && rd_flag) load_o  <= 1'b1;
        if (cnt >  C_FIRST && rd_flag) shift_o <= 1'b1;
        if (cnt == C_LAST && !rd_flag) wr_o    <= 1'b1;
      end
    end
  end

  // address and write data hold until overwritten
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (cs_s && take) begin
      if (cnt == C_FLAG)
        addr_o <= sh[ADDR_W-1:0];
      if (cnt == C_LAST && !rd_flag)
        wdata_o <= {sh[DATA_W-2:0], sdi_s};
    end
  end
endmodule

// File: rtl/sio_rd_drv.sv
module sio_rd_drv #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] rdata,
  output logic              sdo,
  output logic              sdo_oe
);
  logic [DATA_W-2:0] rest;

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
      rest   <= '0;
    end else begin
      if (!cs_s)     sdo_oe <= 1'b0;
      else if (load) sdo_oe <= 1'b1;

      if (load) begin
        sdo  <= rdata[DATA_W-1];
        rest <= rdata[DATA_W-2:0];
      end else if (shift) begin
        sdo  <= rest[DATA_W-2];
        rest <= rest << 1;
      end
    end
  end
endmodule

// File: rtl/sio_reg_slave.sv
module sio_reg_slave #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              csel,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic cs_s, sclk_s, sdi_s, sclk_prev, sclk_rise;
  logic load, shift;

  sio_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({csel, sclk, sdi}),
    .q   ({cs_s, sclk_s, sdi_s})
  );

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_prev & cs_s;

  sio_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .cs_s    (cs_s),
    .rise    (sclk_rise),
    .sdi_s   (sdi_s),
    .addr_o  (reg_addr),
    .wdata_o (reg_wdata),
    .wr_o    (reg_wr),
    .rd_o    (reg_rd),
    .load_o  (load),
    .shift_o (shift)
  );

  sio_rd_drv #(.DATA_W(DATA_W)) u_drv (
    .clk    (clk),
    .rst    (rst),
    .cs_s   (cs_s),
    .load   (load),
    .shift  (shift),
    .rdata  (reg_rdata),
    .sdo    (sdo),
    .sdo_oe (sdo_oe)
  );
endmodule

// File: rtl/sio_reg_slave_chk.sv
module sio_reg_slave_chk (
  input logic clk,
  input logic rst,
  input logic cs_s,
  input logic sclk_rise,
  input logic reg_wr,
  input logic reg_rd,
  input logic sdo,
  input logic sdo_oe
);
  // R3
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);
  // R3
  wr_rd_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));
  // R5
  rd_single_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> !reg_rd);
  // R4
  wr_cs_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> cs_s);
  // R7
  oe_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> !sdo_oe);
  // R7
  oe_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> $past(sclk_rise, 2));
  // R6
  sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(sclk_rise) |=> $stable(sdo));
endmodule

bind sio_reg_slave sio_reg_slave_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_s      (cs_s),
  .sclk_rise (sclk_rise),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .sdo       (sdo),
  .sdo_oe    (sdo_oe)
);

// File: tb/sim_sio_reg_slave.sv
module sim_sio_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int GAP        = 10;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int SYNC       = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, csel = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, reg_wr, reg_rd;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] reg_wdata;
  logic [DATA_W-1:0] reg_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  int wr_cnt = 0, rd_cnt = 0;
  logic [ADDR_W-1:0] wr_a, rd_a;
  logic [DATA_W-1:0] wr_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_reg_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .csel(csel), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] bank_val(input logic [6:0] a);
    return 8'((int'(a) * 73 + 29) & 255);
  endfunction

  function automatic logic [7:0] wr_val(input logic [6:0] a);
    return 8'(((int'(a) * 5 + 60) ^ (int'(a) << 1)) & 255);
  endfunction

  // bank model with one cycle read latency, plus strobe monitor
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      if (reg_rd) begin
        reg_rdata <= bank_val(reg_addr);
        rd_cnt    <= rd_cnt + 1;
        rd_a      <= reg_addr;
      end
      if (reg_wr) begin
        wr_cnt <= wr_cnt + 1;
        wr_a   <= reg_addr;
        wr_d   <= reg_wdata;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame of nrise clock pulses; returns the byte seen on sdo and
  // whether the enable ever differed from its expected value
  task automatic run_frame(input logic [15:0] fr, input int nrise,
                           output logic [7:0] got, output bit oe_bad,
                           output bit tail_bad, input bit end_frame);
    bit is_rd;
    is_rd    = fr[8];
    got      = '0;
    oe_bad   = 1'b0;
    tail_bad = 1'b0;
    csel     = 1'b1;
    wait_clk(HALF);
    for (int i = 0; i < nrise; i++) begin
      if (i < 16) sdi = (is_rd && i >= 9) ? 1'b1 : fr[15-i];
      else        sdi = 1'b1;
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      if (sdo_oe !== (is_rd && i >= 8)) oe_bad = 1'b1;
      if (is_rd && i >= 8 && i < 16) got[15-i] = sdo;
      if (is_rd && i >= 16 && sdo !== got[0]) tail_bad = 1'b1;
      sclk = 1'b0;
    end
    wait_clk(HALF);
    if (end_frame) begin
      csel = 1'b0;
      wait_clk(GAP);
    end
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, input int nrise);
    int w0, r0;
    logic [7:0] got;
    bit oe_bad, tail_bad;
    w0 = wr_cnt; r0 = rd_cnt;
    run_frame({a, 1'b0, d}, nrise, got, oe_bad, tail_bad, 1'b1);
    if (nrise >= 16) begin
      // R2
      check(wr_cnt == w0 + 1 && wr_a == a && wr_d == d, "R2",
            {wr_cnt - w0, 8'(wr_a), wr_d}, {1, 8'(a), d});
      if (nrise > 16)   // R9: extra edges add no write
        check(wr_cnt == w0 + 1, "R9", wr_cnt - w0, 1);
    end else begin
      // R4
      check(wr_cnt == w0, "R4", wr_cnt - w0, 0);
    end
    // R3
    check(rd_cnt == r0, "R3", rd_cnt - r0, 0);
    // R7
    check(!oe_bad, "R7", oe_bad, 0);
  endtask

  task automatic do_read(input logic [6:0] a, input int nrise);
    int w0, r0;
    logic [7:0] got;
    bit oe_bad, tail_bad;
    w0 = wr_cnt; r0 = rd_cnt;
    run_frame({a, 1'b1, 8'h00}, nrise, got, oe_bad, tail_bad, 1'b0);
    // R5
    check(rd_cnt == r0 + 1 && rd_a == a && wr_cnt == w0, "R5",
          {rd_cnt - r0, 8'(rd_a)}, {1, 8'(a)});
    // R6
    check(got == bank_val(a), "R6", got, bank_val(a));
    // R7
    check(!oe_bad, "R7", oe_bad, 0);
    if (nrise > 16)  // R9
      check(!tail_bad, "R9", tail_bad, 0);
    // R10: enable drops exactly SYNC+1 edges after select falls
    csel = 1'b0;
    wait_clk(SYNC);
    check(sdo_oe === 1'b1, "R10", sdo_oe, 1);
    wait_clk(1);
    check(sdo_oe === 1'b0, "R10", sdo_oe, 0);
    wait_clk(GAP);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    wait_clk(5);
    // R1
    check(sdo_oe === 1'b0, "R1", sdo_oe, 0);
    check(sdo === 1'b0, "R1", sdo, 0);
    check(reg_wr === 1'b0, "R1", reg_wr, 0);
    check(reg_rd === 1'b0, "R1", reg_rd, 0);
    rst = 1'b0;
    wait_clk(5);

    for (int a = 0; a < 128; a++) do_write(7'(a), wr_val(7'(a)), 16);
    for (int a = 0; a < 128; a++) do_read(7'(a), 16);

    // R4 aborts followed by clean frames (R8)
    do_write(7'h55, 8'hA5, 5);
    do_write(7'h2A, 8'h3C, 16);   // R8
    do_write(7'h7F, 8'hFF, 15);
    do_write(7'h00, 8'h00, 10);
    do_write(7'h01, 8'h80, 16);   // R8
    do_read (7'h33, 16);

    // R9 overlong frames
    do_write(7'h11, 8'h96, 20);
    do_read (7'h45, 18);
    do_read (7'h12, 19);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end
endmodule